// File: doc/BRIEF.md
# Snooping Cache Line State Controller

This block holds the coherence state of every line in a snooping cache and updates it one event at a time. Three kinds of event arrive: requests from the processor side that look for a hit, fills that complete a miss from the memory side, and snoops from other caches on the memory side. For each accepted event the block reports the line's state before and after the event. It also reports whether the request was satisfied and whether the requester gets a reply, together with the flags that go onto the bus response: shared, memory-inhibit, supply-exclusive and data-attached. Tag matching, data arrays and victim choice belong to the surrounding cache, which presents a line index with each event.

Each line is in one of five named states, held as the bits {Valid, Writable, Dirty}. The states are Invalid `000`, Shared `100`, Owned `101` (dirty but read-only), Exclusive `110` and Modified `111`. At most one event is taken per cycle. A snoop always wins, a fill beats a processor request, and an event that loses keeps its request asserted until it is granted. The event is processed at the clock edge where it is granted, and its report is valid during the following cycle.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (`000`) and `evt_valid` is low until an event is accepted.
- R2: A snoop is always accepted; a fill is granted only without a snoop; a processor request is granted only with neither. The report of an event granted at one edge appears with `evt_valid` high in the next cycle, with `evt_src` 1 for processor, 2 for fill and 3 for snoop.
- R3: Processor op codes are 0 read, 1 write, 2 block read, 3 exclusive block read, 4 upgrade, 5 writeback. Codes 1, 3, 4 and 5 hit only on a Writable line, except as R7 states. Codes 0 and 2 hit on any Valid line. A miss, or codes 6 and 7, reports hit 0 and reply 0 and leaves the state unchanged.
- R4: A write hit makes the line Modified (`111`) and replies.
- R5: An exclusive block read hit or an upgrade hit makes the line Invalid and replies.
- R6: A block read hit reports shared, replies, clears Writable and keeps Dirty (Exclusive becomes Shared, Modified becomes Owned).
- R7: A writeback never replies. On a Writable line it hits and gives Modified. On a Valid line that is not Writable it hits and sets Dirty while Writable stays clear (gives Owned). On an Invalid line it misses.
- R8: A fill reports hit 1. It leaves the line Exclusive (`110`) when `fill_excl` is high or `fill_shared` is low, and Shared (`100`) otherwise, whatever the old state was (Dirty is cleared).
- R9: A snoop to an Invalid line reports hit 0, all four flags low and the state unchanged.
- R10: A snoop to a Valid line asserts memory-inhibit only when the line is Dirty and `snp_need_rsp` is high. Supply-exclusive is asserted with it when the line was Writable, and data-attached is asserted with it when the snoop is a read.
- R11: A read snoop without invalidate to a Valid line asserts shared, clears Writable and keeps Dirty.
- R12: A snoop with invalidate leaves the line Invalid and does not assert shared. Its response flags are decided from the state held before the invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor-side request present |
| cpu_op | input | 3 | Processor op code (see R3) |
| cpu_idx | input | IDX_W | Line index of the processor request |
| cpu_gnt | output | 1 | Processor request taken at this edge |
| fill_req | input | 1 | Fill present |
| fill_idx | input | IDX_W | Line index of the fill |
| fill_excl | input | 1 | The miss being filled needed exclusive access |
| fill_shared | input | 1 | The fill response carried the shared flag |
| fill_gnt | output | 1 | Fill taken at this edge |
| snp_req | input | 1 | Snoop present (always taken) |
| snp_idx | input | IDX_W | Line index of the snoop |
| snp_read | input | 1 | Snoop reads data |
| snp_inval | input | 1 | Snoop invalidates other copies |
| snp_need_rsp | input | 1 | Snoop expects a response |
| evt_valid | output | 1 | Report of the previous cycle's event is valid |
| evt_src | output | 2 | Event source: 1 processor, 2 fill, 3 snoop |
| evt_idx | output | IDX_W | Line index of the reported event |
| evt_hit | output | 1 | Processor request satisfied / fill done / snoop found Valid line |
| evt_reply | output | 1 | Processor requester receives a response |
| evt_old | output | 3 | Line state {V,W,D} before the event |
| evt_new | output | 3 | Line state {V,W,D} after the event |
| evt_shared | output | 1 | Shared flag on the response |
| evt_inhibit | output | 1 | Memory-inhibit: this cache supplies the data |
| evt_supply_ex | output | 1 | Supplied copy was held exclusively |
| evt_data | output | 1 | Response carries line data |

## Verification
A snoop and a processor request can reach the controller in the same cycle, and both may address the same line. The bench presents a write and a read snoop to one Exclusive line together. It checks that the processor grant is low during that cycle and that the report shows the snoop moving the line to Shared. It then keeps the write asserted, sees the grant rise, and checks that the write is judged against the post-snoop state, so it misses. The same kind of collision is repeated for a fill against a processor read and for all three sources at once.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;

    // Line state, bits {valid, writable, dirty}
    typedef enum logic [2:0] {
        LS_INV = 3'b000,
        LS_SHR = 3'b100,
        LS_OWN = 3'b101,
        LS_EXC = 3'b110,
        LS_MOD = 3'b111
    } line_st_e;

    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_RDBLK    = 3'd2,
        OP_RDBLK_EX = 3'd3,
        OP_UPGRADE  = 3'd4,
        OP_WBACK    = 3'd5
    } cpu_op_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_FILL = 2'd2,
        SRC_SNP  = 2'd3
    } evt_src_e;

    typedef struct packed {
        logic     hit;
        logic     reply;
        line_st_e new_st;
        logic     shared;
        logic     inhibit;
        logic     supply_ex;
        logic     data;
    } coh_res_t;

    function automatic logic st_valid(line_st_e s);
        return s[2];
    endfunction

    function automatic logic st_writable(line_st_e s);
        return s[1];
    endfunction

    function automatic logic st_dirty(line_st_e s);
        return s[0];
    endfunction

    // Remove write permission, keep ownership of dirty data
    function automatic line_st_e drop_write(line_st_e s);
        case (s)
            LS_EXC:  return LS_SHR;
            LS_MOD:  return LS_OWN;
            default: return s;
        endcase
    endfunction

endpackage

// File: rtl/coh_arbiter.sv
`timescale 1ns/1ps
module coh_arbiter
    import coh_pkg::*;
(
    input  logic     snp_req,
    input  logic     fill_req,
    input  logic     cpu_req,
    output logic     fill_go,
    output logic     cpu_go,
    output evt_src_e sel
);

    always_comb begin
        fill_go = 1'b0;
        cpu_go  = 1'b0;
        sel     = SRC_NONE;
        if (snp_req) begin
            sel = SRC_SNP;
        end else if (fill_req) begin
            sel     = SRC_FILL;
            fill_go = 1'b1;
        end else if (cpu_req) begin
            sel    = SRC_CPU;
            cpu_go = 1'b1;
        end
    end

endmodule

// File: rtl/coh_line_store.sv
`timescale 1ns/1ps
module coh_line_store
    import coh_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_e         wr_st,
    input  logic [IDX_W-1:0] rd_idx,
    output line_st_e         rd_st
);

    line_st_e lines [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lines[g] <= LS_INV;
            end else if (we && (wr_idx == IDX_W'(g))) begin
                lines[g] <= wr_st;
            end
        end
    end

    assign rd_st = lines[rd_idx];

endmodule

// File: rtl/coh_transition.sv
`timescale 1ns/1ps
module coh_transition
    import coh_pkg::*;
(
    input  evt_src_e   src,
    input  line_st_e   old_st,
    input  logic [2:0] cpu_op,
    input  logic       fill_excl,
    input  logic       fill_shared,
    input  logic       snp_read,
    input  logic       snp_inval,
    input  logic       snp_need_rsp,
    output coh_res_t   res
);

    cpu_op_e op;
    logic    answer;

    assign op     = cpu_op_e'(cpu_op);
    assign answer = st_dirty(old_st) && snp_need_rsp;

    always_comb begin
        res.hit       = 1'b0;
        res.reply     = 1'b0;
        res.new_st    = old_st;
        res.shared    = 1'b0;
        res.inhibit   = 1'b0;
        res.supply_ex = 1'b0;
        res.data      = 1'b0;
        unique case (src)
            SRC_CPU: begin
                unique case (op)
                    OP_READ: begin
                        if (st_valid(old_st)) begin
                            res.hit   = 1'b1;
                            res.reply = 1'b1;
                        end
                    end
                    OP_WRITE: begin
                        if (st_writable(old_st)) begin
                            res.hit    = 1'b1;
                            res.reply  = 1'b1;
                            res.new_st = LS_MOD;
                        end
                    end
                    OP_RDBLK: begin
                        if (st_valid(old_st)) begin
                            res.hit    = 1'b1;
                            res.reply  = 1'b1;
                            res.shared = 1'b1;
                            res.new_st = drop_write(old_st);
                        end
                    end
                    OP_RDBLK_EX, OP_UPGRADE: begin
                        if (st_writable(old_st)) begin
                            res.hit    = 1'b1;
                            res.reply  = 1'b1;
                            res.new_st = LS_INV;
                        end
                    end
                    OP_WBACK: begin
                        if (st_writable(old_st)) begin
                            res.hit    = 1'b1;
                            res.new_st = LS_MOD;
                        end else if (st_valid(old_st)) begin
                            res.hit    = 1'b1;
                            res.new_st = LS_OWN;
                        end
                    end
                    default: ;
                endcase
            end
            SRC_FILL: begin
                res.hit    = 1'b1;
                res.new_st = (fill_excl || !fill_shared) ? LS_EXC : LS_SHR;
            end
            SRC_SNP: begin
                if (st_valid(old_st)) begin
                    res.hit       = 1'b1;
                    res.shared    = snp_read && !snp_inval;
                    res.inhibit   = answer;
                    res.supply_ex = answer && st_writable(old_st);
                    res.data      = answer && snp_read;
                    if (snp_inval) begin
                        res.new_st = LS_INV;
                    end else if (snp_read) begin
                        res.new_st = drop_write(old_st);
                    end
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_line_ctrl.sv
`timescale 1ns/1ps
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter  int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic [2:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_gnt,
    input  logic             fill_req,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_excl,
    input  logic             fill_shared,
    output logic             fill_gnt,
    input  logic             snp_req,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic             snp_read,
    input  logic             snp_inval,
    input  logic             snp_need_rsp,
    output logic             evt_valid,
    output logic [1:0]       evt_src,
    output logic [IDX_W-1:0] evt_idx,
    output logic             evt_hit,
    output logic             evt_reply,
    output logic [2:0]       evt_old,
    output logic [2:0]       evt_new,
    output logic             evt_shared,
    output logic             evt_inhibit,
    output logic             evt_supply_ex,
    output logic             evt_data
);

    evt_src_e         sel;
    logic [IDX_W-1:0] idx;
    line_st_e         old_st;
    coh_res_t         res;

    coh_arbiter u_arb (
        .snp_req  (snp_req),
        .fill_req (fill_req),
        .cpu_req  (cpu_req),
        .fill_go  (fill_gnt),
        .cpu_go   (cpu_gnt),
        .sel      (sel)
    );

    always_comb begin
        unique case (sel)
            SRC_SNP:  idx = snp_idx;
            SRC_FILL: idx = fill_idx;
            default:  idx = cpu_idx;
        endcase
    end

    coh_line_store #(.LINES(LINES), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sel != SRC_NONE),
        .wr_idx (idx),
        .wr_st  (res.new_st),
        .rd_idx (idx),
        .rd_st  (old_st)
    );

    coh_transition u_next (
        .src          (sel),
        .old_st       (old_st),
        .cpu_op       (cpu_op),
        .fill_excl    (fill_excl),
        .fill_shared  (fill_shared),
        .snp_read     (snp_read),
        .snp_inval    (snp_inval),
        .snp_need_rsp (snp_need_rsp),
        .res          (res)
    );

    // Report register: one cycle after the event is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid     <= 1'b0;
            evt_src       <= 2'd0;
            evt_idx       <= '0;
            evt_hit       <= 1'b0;
            evt_reply     <= 1'b0;
            evt_old       <= 3'b000;
            evt_new       <= 3'b000;
            evt_shared    <= 1'b0;
            evt_inhibit   <= 1'b0;
            evt_supply_ex <= 1'b0;
            evt_data      <= 1'b0;
        end else begin
            evt_valid     <= (sel != SRC_NONE);
            evt_src       <= sel;
            evt_idx       <= idx;
            evt_hit       <= res.hit;
            evt_reply     <= res.reply;
            evt_old       <= old_st;
            evt_new       <= res.new_st;
            evt_shared    <= res.shared;
            evt_inhibit   <= res.inhibit;
            evt_supply_ex <= res.supply_ex;
            evt_data      <= res.data;
        end
    end

    // R2
    cpu_grant_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |=> evt_valid && evt_src == 2'd1);

    // R2
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req |=> evt_valid && evt_src == 2'd3);

    // R3
    miss_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_src == 2'd1 && !evt_hit) |-> (evt_new == evt_old && !evt_reply));

    // R4
    write_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && cpu_op == 3'd1) |=> (!evt_hit || evt_new == 3'b111));

    // R7
    wback_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && cpu_op == 3'd5) |=> (!evt_reply && (!evt_hit || evt_new[0])));

    // R8
    fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_src == 2'd2) |-> (evt_new[2] && !evt_new[0]));

    // R9
    snoop_idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_src == 2'd3 && !evt_old[2])
            |-> (evt_new == 3'b000 && !evt_inhibit && !evt_shared && !evt_data));

    // R10
    supply_needs_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_supply_ex |-> (evt_inhibit && evt_old[1] && evt_old[0]));

    // R12
    inval_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_req && snp_inval) |=> (evt_new == 3'b000 && !evt_shared));

endmodule

// File: tb/tb_coh_line_ctrl.sv
`timescale 1ns/1ps
module tb_coh_line_ctrl;

    localparam int LINES = 16;
    localparam int IW    = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic [2:0]    cpu_op = 3'd0;
    logic [IW-1:0] cpu_idx = '0;
    logic          cpu_gnt;
    logic          fill_req = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic          fill_excl = 1'b0;
    logic          fill_shared = 1'b0;
    logic          fill_gnt;
    logic          snp_req = 1'b0;
    logic [IW-1:0] snp_idx = '0;
    logic          snp_read = 1'b0;
    logic          snp_inval = 1'b0;
    logic          snp_need_rsp = 1'b0;
    logic          evt_valid;
    logic [1:0]    evt_src;
    logic [IW-1:0] evt_idx;
    logic          evt_hit, evt_reply;
    logic [2:0]    evt_old, evt_new;
    logic          evt_shared, evt_inhibit, evt_supply_ex, evt_data;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    coh_line_ctrl #(.LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_idx(cpu_idx), .cpu_gnt(cpu_gnt),
        .fill_req(fill_req), .fill_idx(fill_idx), .fill_excl(fill_excl),
        .fill_shared(fill_shared), .fill_gnt(fill_gnt),
        .snp_req(snp_req), .snp_idx(snp_idx), .snp_read(snp_read),
        .snp_inval(snp_inval), .snp_need_rsp(snp_need_rsp),
        .evt_valid(evt_valid), .evt_src(evt_src), .evt_idx(evt_idx),
        .evt_hit(evt_hit), .evt_reply(evt_reply), .evt_old(evt_old),
        .evt_new(evt_new), .evt_shared(evt_shared), .evt_inhibit(evt_inhibit),
        .evt_supply_ex(evt_supply_ex), .evt_data(evt_data)
    );

    task automatic chk(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // flags packed as {shared, inhibit, supply_ex, data}
    task automatic expect_evt(string rq, int src, int idx, int hit, int reply,
                              int old_s, int new_s, int flags);
        chk(rq, "evt_valid", int'(evt_valid), 1);
        chk(rq, "evt_src", int'(evt_src), src);
        chk(rq, "evt_idx", int'(evt_idx), idx);
        chk(rq, "evt_hit", int'(evt_hit), hit);
        chk(rq, "evt_reply", int'(evt_reply), reply);
        chk(rq, "evt_old", int'(evt_old), old_s);
        chk(rq, "evt_new", int'(evt_new), new_s);
        chk(rq, "flags", int'({evt_shared, evt_inhibit, evt_supply_ex, evt_data}), flags);
    endtask

    task automatic clear_inputs();
        cpu_req = 1'b0; fill_req = 1'b0; snp_req = 1'b0;
    endtask

    task automatic cpu_do(int op, int idx);
        cpu_req = 1'b1; cpu_op = 3'(op); cpu_idx = IW'(idx);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic fill_do(int idx, bit ex, bit sh);
        fill_req = 1'b1; fill_idx = IW'(idx); fill_excl = ex; fill_shared = sh;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic snp_set(int idx, bit rd, bit inv, bit nr);
        snp_req = 1'b1; snp_idx = IW'(idx); snp_read = rd; snp_inval = inv; snp_need_rsp = nr;
    endtask

    task automatic snp_do(int idx, bit rd, bit inv, bit nr);
        snp_set(idx, rd, inv, nr);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic t_reset();
        chk("R1", "evt_valid after reset", int'(evt_valid), 0);
        cpu_do(0, 0);
        expect_evt("R1", 1, 0, 0, 0, 3'b000, 3'b000, 0);
        @(negedge clk);
        chk("R1", "evt_valid idle", int'(evt_valid), 0);
    endtask

    task automatic t_fill();
        fill_do(1, 1'b0, 1'b1);
        expect_evt("R8", 2, 1, 1, 0, 3'b000, 3'b100, 0);
        fill_do(2, 1'b0, 1'b0);
        expect_evt("R8", 2, 2, 1, 0, 3'b000, 3'b110, 0);
        fill_do(3, 1'b1, 1'b1);
        expect_evt("R8", 2, 3, 1, 0, 3'b000, 3'b110, 0);
    endtask

    task automatic t_hits();
        cpu_do(0, 1);
        expect_evt("R3", 1, 1, 1, 1, 3'b100, 3'b100, 0);
        cpu_do(1, 1);
        expect_evt("R3", 1, 1, 0, 0, 3'b100, 3'b100, 0);
        cpu_do(4, 1);
        expect_evt("R3", 1, 1, 0, 0, 3'b100, 3'b100, 0);
        cpu_do(1, 2);
        expect_evt("R4", 1, 2, 1, 1, 3'b110, 3'b111, 0);
        cpu_do(1, 2);
        expect_evt("R4", 1, 2, 1, 1, 3'b111, 3'b111, 0);
        cpu_do(7, 1);
        expect_evt("R3", 1, 1, 0, 0, 3'b100, 3'b100, 0);
    endtask

    task automatic t_block();
        cpu_do(2, 2);
        expect_evt("R6", 1, 2, 1, 1, 3'b111, 3'b101, 4'b1000);
        cpu_do(2, 1);
        expect_evt("R6", 1, 1, 1, 1, 3'b100, 3'b100, 4'b1000);
        cpu_do(3, 3);
        expect_evt("R5", 1, 3, 1, 1, 3'b110, 3'b000, 0);
        fill_do(3, 1'b1, 1'b0);
        expect_evt("R8", 2, 3, 1, 0, 3'b000, 3'b110, 0);
        cpu_do(4, 3);
        expect_evt("R5", 1, 3, 1, 1, 3'b110, 3'b000, 0);
        cpu_do(3, 2);
        expect_evt("R3", 1, 2, 0, 0, 3'b101, 3'b101, 0);
    endtask

    task automatic t_wback();
        cpu_do(5, 2);
        expect_evt("R7", 1, 2, 1, 0, 3'b101, 3'b101, 0);
        cpu_do(5, 1);
        expect_evt("R7", 1, 1, 1, 0, 3'b100, 3'b101, 0);
        cpu_do(5, 5);
        expect_evt("R7", 1, 5, 0, 0, 3'b000, 3'b000, 0);
        fill_do(6, 1'b1, 1'b1);
        expect_evt("R8", 2, 6, 1, 0, 3'b000, 3'b110, 0);
        cpu_do(5, 6);
        expect_evt("R7", 1, 6, 1, 0, 3'b110, 3'b111, 0);
        fill_do(6, 1'b0, 1'b1);
        expect_evt("R8", 2, 6, 1, 0, 3'b111, 3'b100, 0);
        fill_do(6, 1'b1, 1'b0);
        expect_evt("R8", 2, 6, 1, 0, 3'b100, 3'b110, 0);
        cpu_do(1, 6);
        expect_evt("R4", 1, 6, 1, 1, 3'b110, 3'b111, 0);
    endtask

    task automatic t_snoop();
        snp_do(7, 1'b1, 1'b0, 1'b1);
        expect_evt("R9", 3, 7, 0, 0, 3'b000, 3'b000, 0);
        snp_do(6, 1'b1, 1'b0, 1'b1);
        expect_evt("R10", 3, 6, 1, 0, 3'b111, 3'b101, 4'b1111);
        snp_do(2, 1'b1, 1'b1, 1'b1);
        expect_evt("R12", 3, 2, 1, 0, 3'b101, 3'b000, 4'b0101);
        snp_do(1, 1'b1, 1'b0, 1'b0);
        expect_evt("R11", 3, 1, 1, 0, 3'b101, 3'b101, 4'b1000);
        snp_do(6, 1'b0, 1'b1, 1'b1);
        expect_evt("R12", 3, 6, 1, 0, 3'b101, 3'b000, 4'b0100);
        snp_do(0, 1'b1, 1'b1, 1'b1);
        expect_evt("R9", 3, 0, 0, 0, 3'b000, 3'b000, 0);
        cpu_do(0, 7);
        expect_evt("R9", 1, 7, 0, 0, 3'b000, 3'b000, 0);
    endtask

    task automatic t_collide();
        fill_do(8, 1'b1, 1'b0);
        expect_evt("R8", 2, 8, 1, 0, 3'b000, 3'b110, 0);
        // snoop and processor write to the same line together
        cpu_req = 1'b1; cpu_op = 3'd1; cpu_idx = IW'(8);
        snp_set(8, 1'b1, 1'b0, 1'b1);
        #1;
        chk("R2", "cpu_gnt under snoop", int'(cpu_gnt), 0);
        chk("R2", "fill_gnt under snoop", int'(fill_gnt), 0);
        @(negedge clk);
        snp_req = 1'b0;
        expect_evt("R11", 3, 8, 1, 0, 3'b110, 3'b100, 4'b1000);
        #1;
        chk("R2", "cpu_gnt after snoop", int'(cpu_gnt), 1);
        @(negedge clk);
        clear_inputs();
        expect_evt("R2", 1, 8, 0, 0, 3'b100, 3'b100, 0);
        // fill against processor read
        cpu_req = 1'b1; cpu_op = 3'd0; cpu_idx = IW'(9);
        fill_req = 1'b1; fill_idx = IW'(9); fill_excl = 1'b1; fill_shared = 1'b0;
        #1;
        chk("R2", "fill_gnt over cpu", int'(fill_gnt), 1);
        chk("R2", "cpu_gnt under fill", int'(cpu_gnt), 0);
        @(negedge clk);
        fill_req = 1'b0;
        expect_evt("R2", 2, 9, 1, 0, 3'b000, 3'b110, 0);
        @(negedge clk);
        clear_inputs();
        expect_evt("R2", 1, 9, 1, 1, 3'b110, 3'b110, 0);
        // all three at once; plain snoop (no read, no invalidate)
        cpu_req = 1'b1; cpu_op = 3'd0; cpu_idx = IW'(10);
        fill_req = 1'b1; fill_idx = IW'(10); fill_excl = 1'b0; fill_shared = 1'b1;
        snp_set(9, 1'b0, 1'b0, 1'b0);
        #1;
        chk("R2", "fill_gnt with snoop", int'(fill_gnt), 0);
        chk("R2", "cpu_gnt with all", int'(cpu_gnt), 0);
        @(negedge clk);
        snp_req = 1'b0;
        expect_evt("R2", 3, 9, 1, 0, 3'b110, 3'b110, 0);
        @(negedge clk);
        fill_req = 1'b0;
        expect_evt("R2", 2, 10, 1, 0, 3'b000, 3'b100, 0);
        @(negedge clk);
        clear_inputs();
        expect_evt("R2", 1, 10, 1, 1, 3'b100, 3'b100, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_hits();
        t_block();
        t_wback();
        t_snoop();
        t_collide();
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule